// File: doc/BRIEF.md
# Single-Frame Receive Staging Buffer

The block sits between a MAC receive byte stream and a DMA engine and holds at most one Ethernet frame. Bytes arrive one per cycle with start-of-frame and end-of-frame markers. A frame becomes visible to the DMA side only once its final byte is stored. Its stored length is the received byte count plus four, so that room for the frame check sequence reaches the consumer. The four trailing positions read as zero.

The DMA side asks for a chunk by pulsing a request with a byte limit. The block then streams the lesser of that limit and the remaining length, one byte per cycle, from its read position. It flags the final byte of each chunk and the byte that empties the buffer. Once the buffer is empty it accepts a new frame again. A frame that starts while a frame is still held is dropped whole and counted as a loss. A frame longer than the capacity is discarded and counted as oversize. Both counters saturate and are cleared by a strobe.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset rx_ready_o is 1, frame_avail_o is 0, dma_remain_o is 0, dma_valid_o is 0 and both event counters are 0.
- R2: The cycle after the end-of-frame byte of an accepted frame of N bytes, rx_ready_o is 0, frame_avail_o is 1 and dma_remain_o is N+4.
- R3: A pull request with limit L, sampled on a clock edge while no chunk is streaming, yields min(L, remaining) bytes on consecutive cycles, starting one cycle after that edge. The bytes are the frame in arrival order from the read position, and the four positions after the received bytes read 0x00.
- R4: dma_chunk_end_o is 1 on the final byte of every chunk. dma_last_o is 1 only on the byte that brings the remaining length to zero.
- R5: The cycle after the last byte is delivered, frame_avail_o is 0 and rx_ready_o is 1. The two are never 1 together.
- R6: A start-of-frame that arrives while a frame is held adds one to loss_cnt_o, and none of its bytes are stored. The held frame is delivered unchanged.
- R7: A frame of more than 1536 bytes is discarded, adds one to ovs_cnt_o, and leaves rx_ready_o at 1 and frame_avail_o at 0. A frame of exactly 1536 bytes is accepted with length 1540.
- R8: While a frame is still arriving, frame_avail_o stays 0 and pull requests produce no bytes.
- R9: Each counter is 16 bits wide and holds at 65535. A cnt_clr_i pulse sets both counters to 0 on the next cycle.
- R10: A pull request with a limit of zero, or one made while a chunk is streaming, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | Byte is first of frame |
| rx_eof_i | input | 1 | Byte is last of frame |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | No frame held; a new frame is accepted |
| frame_avail_o | output | 1 | A complete frame is held for the DMA |
| dma_remain_o | output | 11 | Bytes left to drain, FCS room included |
| dma_req_i | input | 1 | Pull request strobe |
| dma_req_len_i | input | 11 | Byte limit of the pull |
| dma_valid_o | output | 1 | Output byte valid |
| dma_data_o | output | 8 | Output byte |
| dma_chunk_end_o | output | 1 | Final byte of the current chunk |
| dma_last_o | output | 1 | Byte that empties the buffer |
| cnt_clr_i | input | 1 | Clear both event counters |
| loss_cnt_o | output | 16 | Frames lost while the buffer was held |
| ovs_cnt_o | output | 16 | Oversize frames discarded |

## Verification
The status outputs change on the edge that takes the end-of-frame byte, or the last drained byte. The bench reads them at the falling edge that follows, one cycle after the stimulus. The counters follow the same one-cycle rule after the start-of-frame (loss), the end-of-frame (oversize) or the clear strobe. After a pull is sampled, the first byte arrives on the next edge and one byte follows per cycle. For each request the driver queues the expected bytes and flags, and a falling-edge monitor pops and compares every valid byte. Any byte with no queued entry counts as a failure, and so does a queue that is not empty after the pull window.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  typedef enum logic [1:0] {
    S_EMPTY = 2'd0,
    S_FILL  = 2'd1,
    S_OVS   = 2'd2,
    S_FULL  = 2'd3
  } wr_state_e;

  localparam int unsigned EV_LOSS = 0;
  localparam int unsigned EV_OVS  = 1;
  localparam int unsigned N_EV    = 2;
endpackage

// File: rtl/rfb_mem.sv
module rfb_mem #(
  parameter int unsigned DEPTH = 1536,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  p_wr_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(waddr_i) < DEPTH));
endmodule

// File: rtl/rfb_wr.sv
module rfb_wr
  import rfb_pkg::*;
#(
  parameter int unsigned CAP   = 1536,
  parameter int unsigned LEN_W = 11,
  parameter int unsigned AW    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic             rx_sof_i,
  input  logic             rx_eof_i,
  input  logic             done_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic             commit_o,
  output logic [LEN_W-1:0] commit_len_o,
  output logic             loss_o,
  output logic             ovs_o,
  output logic             ready_o
);
  wr_state_e        state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    we_o         = 1'b0;
    waddr_o      = cnt_q[AW-1:0];
    commit_o     = 1'b0;
    commit_len_o = cnt_q + LEN_W'(1);
    loss_o       = 1'b0;
    ovs_o        = 1'b0;
    unique case (state_q)
      S_EMPTY, S_FILL: begin
        if (rx_valid_i && rx_sof_i) begin
          // start (or restart) at position zero
          we_o         = 1'b1;
          waddr_o      = '0;
          commit_len_o = LEN_W'(1);
          if (rx_eof_i) begin
            commit_o = 1'b1;
            state_d  = S_FULL;
          end else begin
            cnt_d   = LEN_W'(1);
            state_d = S_FILL;
          end
        end else if (rx_valid_i && state_q == S_FILL) begin
          if (32'(cnt_q) == CAP) begin
            if (rx_eof_i) begin
              ovs_o   = 1'b1;
              state_d = S_EMPTY;
            end else begin
              state_d = S_OVS;
            end
          end else begin
            we_o = 1'b1;
            if (rx_eof_i) begin
              commit_o = 1'b1;
              state_d  = S_FULL;
            end else begin
              cnt_d = cnt_q + LEN_W'(1);
            end
          end
        end
      end
      S_OVS: begin
        if (rx_valid_i && rx_eof_i) begin
          ovs_o   = 1'b1;
          state_d = S_EMPTY;
        end
      end
      S_FULL: begin
        loss_o = rx_valid_i && rx_sof_i;
        if (done_i) state_d = S_EMPTY;
      end
      default: state_d = S_EMPTY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_EMPTY;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ready_o = (state_q != S_FULL);

  p_loss_keeps_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FULL && rx_valid_i && rx_sof_i && !done_i) |=> state_q == S_FULL);
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= CAP);
endmodule

// File: rtl/rfb_rd.sv
module rfb_rd #(
  parameter int unsigned FCS   = 4,
  parameter int unsigned LEN_W = 11,
  parameter int unsigned AW    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [LEN_W-1:0] commit_len_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic [AW-1:0]    raddr_o,
  input  logic [7:0]       rdata_i,
  output logic             done_o,
  output logic             avail_o,
  output logic [LEN_W-1:0] remain_o,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             chunk_end_o,
  output logic             last_o
);
  logic [LEN_W-1:0] remain_q, pos_q, dlen_q, burst_q, grant;

  assign grant   = (req_len_i < remain_q) ? req_len_i : remain_q;
  assign raddr_o = pos_q[AW-1:0];
  assign done_o  = (burst_q != '0) && (remain_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q    <= '0;
      pos_q       <= '0;
      dlen_q      <= '0;
      burst_q     <= '0;
      valid_o     <= 1'b0;
      data_o      <= '0;
      chunk_end_o <= 1'b0;
      last_o      <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      chunk_end_o <= 1'b0;
      last_o      <= 1'b0;
      if (commit_i) begin
        remain_q <= commit_len_i + LEN_W'(FCS);
        dlen_q   <= commit_len_i;
        pos_q    <= '0;
      end else if (burst_q != '0) begin
        valid_o     <= 1'b1;
        data_o      <= (pos_q < dlen_q) ? rdata_i : 8'h00;  // FCS room reads zero
        chunk_end_o <= (burst_q == LEN_W'(1));
        last_o      <= (remain_q == LEN_W'(1));
        pos_q       <= pos_q + LEN_W'(1);
        remain_q    <= remain_q - LEN_W'(1);
        burst_q     <= burst_q - LEN_W'(1);
      end else if (req_i && req_len_i != '0 && remain_q != '0) begin
        burst_q <= grant;
      end
    end
  end

  assign avail_o  = (remain_q != '0);
  assign remain_o = remain_q;

  p_burst_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_q <= remain_q);
  p_last_ends_chunk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> chunk_end_o);
  p_empty_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> !avail_o);
endmodule

// File: rtl/rfb_evt_cnt.sv
module rfb_evt_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != MAX)  cnt_o <= cnt_o + W'(1);
  end

  p_sat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX && !clr_i) |=> cnt_o == MAX);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
  import rfb_pkg::*;
#(
  parameter int unsigned CAP   = 1536,
  parameter int unsigned FCS   = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned AW    = $clog2(CAP),
  localparam int unsigned LEN_W = $clog2(CAP + FCS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic             rx_sof_i,
  input  logic             rx_eof_i,
  input  logic [7:0]       rx_data_i,
  output logic             rx_ready_o,
  output logic             frame_avail_o,
  output logic [LEN_W-1:0] dma_remain_o,
  input  logic             dma_req_i,
  input  logic [LEN_W-1:0] dma_req_len_i,
  output logic             dma_valid_o,
  output logic [7:0]       dma_data_o,
  output logic             dma_chunk_end_o,
  output logic             dma_last_o,
  input  logic             cnt_clr_i,
  output logic [CNT_W-1:0] loss_cnt_o,
  output logic [CNT_W-1:0] ovs_cnt_o
);
  logic             we, commit, done;
  logic [AW-1:0]    waddr, raddr;
  logic [7:0]       rdata;
  logic [LEN_W-1:0] commit_len;
  logic [N_EV-1:0]  ev;
  logic [CNT_W-1:0] ev_cnt [N_EV];

  rfb_wr #(.CAP(CAP), .LEN_W(LEN_W), .AW(AW)) u_wr (
    .clk_i, .rst_ni, .rx_valid_i, .rx_sof_i, .rx_eof_i,
    .done_i(done), .we_o(we), .waddr_o(waddr),
    .commit_o(commit), .commit_len_o(commit_len),
    .loss_o(ev[EV_LOSS]), .ovs_o(ev[EV_OVS]), .ready_o(rx_ready_o)
  );

  rfb_mem #(.DEPTH(CAP), .AW(AW)) u_mem (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(rx_data_i),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  rfb_rd #(.FCS(FCS), .LEN_W(LEN_W), .AW(AW)) u_rd (
    .clk_i, .rst_ni, .commit_i(commit), .commit_len_i(commit_len),
    .req_i(dma_req_i), .req_len_i(dma_req_len_i),
    .raddr_o(raddr), .rdata_i(rdata), .done_o(done),
    .avail_o(frame_avail_o), .remain_o(dma_remain_o),
    .valid_o(dma_valid_o), .data_o(dma_data_o),
    .chunk_end_o(dma_chunk_end_o), .last_o(dma_last_o)
  );

  for (genvar g = 0; g < N_EV; g++) begin : g_evt
    rfb_evt_cnt #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .clr_i(cnt_clr_i), .inc_i(ev[g]), .cnt_o(ev_cnt[g])
    );
  end

  assign loss_cnt_o = ev_cnt[EV_LOSS];
  assign ovs_cnt_o  = ev_cnt[EV_OVS];

  p_ready_vs_avail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ready_o && frame_avail_o));
  p_hidden_while_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ready_o && !$past(frame_avail_o)) |-> !dma_valid_o);
endmodule

// File: tb/rx_frame_buf_tb.sv
module rx_frame_buf_tb;
  localparam int CAP = 1536;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_ready, frame_avail;
  logic [10:0] remain;
  logic        dma_req = 0;
  logic [10:0] dma_req_len = 0;
  logic        dma_valid, dma_chunk_end, dma_last;
  logic [7:0]  dma_data;
  logic        cnt_clr = 0;
  logic [15:0] loss_cnt, ovs_cnt;

  int checks = 0, errors = 0;

  typedef struct packed { logic [7:0] d; logic ce; logic la; } exp_t;
  exp_t exp_q[$];

  int model_mem[CAP + 4];
  int model_rem = 0, model_pos = 0;

  always #2 clk = ~clk;

  rx_frame_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_data_i(rx_data),
    .rx_ready_o(rx_ready), .frame_avail_o(frame_avail), .dma_remain_o(remain),
    .dma_req_i(dma_req), .dma_req_len_i(dma_req_len),
    .dma_valid_o(dma_valid), .dma_data_o(dma_data),
    .dma_chunk_end_o(dma_chunk_end), .dma_last_o(dma_last),
    .cnt_clr_i(cnt_clr), .loss_cnt_o(loss_cnt), .ovs_cnt_o(ovs_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: R3/R4 byte stream scoreboard
  always @(negedge clk) begin
    if (rst_n && dma_valid) begin
      if (exp_q.size() == 0) begin
        chk("R3/R8/R10 unexpected byte", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R3 data", int'(dma_data), int'(e.d));
        chk("R4 chunk_end", int'(dma_chunk_end), int'(e.ce));
        chk("R4 last", int'(dma_last), int'(e.la));
      end
    end
  end

  // frame byte value: seed + index
  task automatic send(input int n, input int seed, input bit store, input bit finish = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = finish && (i == n - 1);
      rx_data = 8'(seed + i);
      if (store) model_mem[i] = (seed + i) & 255;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  task automatic load_model(input int n);
    for (int i = n; i < n + 4; i++) model_mem[i] = 0;
    model_rem = n + 4; model_pos = 0;
  endtask

  task automatic pull(input int lim);
    int n;
    n = (lim < model_rem) ? lim : model_rem;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.d  = 8'(model_mem[model_pos + i]);
      e.ce = (i == n - 1);
      e.la = (model_rem - i == 1);
      exp_q.push_back(e);
    end
    model_pos += n; model_rem -= n;
    @(negedge clk); dma_req = 1; dma_req_len = 11'(lim);
    @(negedge clk); dma_req = 0;
    repeat (n + 1) @(negedge clk);
    chk("R3 queue drained", exp_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", rx_ready, 1);
    chk("R1 avail", frame_avail, 0);
    chk("R1 remain", remain, 0);
    chk("R1 valid", dma_valid, 0);
    chk("R1 loss", loss_cnt, 0);
    chk("R1 ovs", ovs_cnt, 0);

    // R8: partial frame invisible
    send(6, 8'h10, 1, 0);
    chk("R8 avail during fill", frame_avail, 0);
    @(negedge clk); dma_req = 1; dma_req_len = 11'd4;
    @(negedge clk); dma_req = 0;
    repeat (3) @(negedge clk);
    chk("R8 ready during fill", rx_ready, 1);
    // tail of frame 10 bytes total
    for (int i = 6; i < 10; i++) begin
      rx_valid = 1; rx_sof = 0; rx_eof = (i == 9); rx_data = 8'(8'h10 + i);
      model_mem[i] = 8'h10 + i;
      @(negedge clk);
    end
    rx_valid = 0; rx_eof = 0;
    load_model(10);
    chk("R2 ready", rx_ready, 0);
    chk("R2 avail", frame_avail, 1);
    chk("R2 remain", remain, 14);

    // R10: zero limit ignored
    @(negedge clk); dma_req = 1; dma_req_len = 0;
    @(negedge clk); dma_req = 0;
    repeat (2) @(negedge clk);
    chk("R10 remain after zero pull", remain, 14);

    pull(6);
    chk("R3 remain after chunk", remain, 8);
    // R10: request during streaming ignored
    exp_q.push_back('{d: 8'(model_mem[6]), ce: 0, la: 0});
    exp_q.push_back('{d: 8'(model_mem[7]), ce: 0, la: 0});
    exp_q.push_back('{d: 8'(model_mem[8]), ce: 1, la: 0});
    @(negedge clk); dma_req = 1; dma_req_len = 11'd3;
    @(negedge clk); dma_req_len = 11'd50;
    @(negedge clk); dma_req = 0;
    repeat (3) @(negedge clk);
    model_pos = 9; model_rem = 5;
    chk("R10 remain", remain, 5);
    pull(100);
    chk("R5 avail", frame_avail, 0);
    chk("R5 ready", rx_ready, 1);

    // R6: loss while held
    send(5, 8'h80, 1);
    load_model(5);
    send(3, 8'hC0, 0);
    chk("R6 loss count", loss_cnt, 1);
    chk("R6 remain unchanged", remain, 9);
    pull(9);
    chk("R5 ready after drain", rx_ready, 1);

    // R7: oversize then exact capacity
    send(CAP + 1, 3, 0);
    chk("R7 ovs count", ovs_cnt, 1);
    chk("R7 ready", rx_ready, 1);
    chk("R7 avail", frame_avail, 0);
    send(CAP, 7, 1);
    load_model(CAP);
    chk("R7 exact remain", remain, CAP + 4);
    pull(2000);
    chk("R7 drained", frame_avail, 0);

    // R9: saturation and clear
    send(1, 1, 1);
    load_model(1);
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = 1; rx_eof = 1;
    end
    @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0;
    chk("R9 saturated", loss_cnt, 65535);
    @(negedge clk); rx_valid = 1; rx_sof = 1; rx_eof = 1;
    @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0;
    chk("R9 held", loss_cnt, 65535);
    cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
    chk("R9 loss cleared", loss_cnt, 0);
    chk("R9 ovs cleared", ovs_cnt, 0);
    pull(5);
    chk("R5 final ready", rx_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule